// File: doc/BRIEF.md
# Reference Clock Switchover Controller

This block chooses which of two incoming clocks drives a PLL reference. One input is a crystal or external reference clock, the other an auxiliary clock. A configuration bit decides which of the two acts as primary and which as secondary. A free-running monitor clock watches both inputs for activity. A policy field selects manual selection, one-way failover, or failover with return to the primary. The chosen clock reaches the output through a mux that never produces a shortened pulse.

Activity is judged per window of monitor-clock cycles. A window with too few edges of the divided input marks that input lost. The input becomes valid again only after a run of active windows. The run is twice as long when the crystal input is driven by an oscillator rather than an external clock. Status outputs give the active source, a sticky loss flag for each input and a flag that both inputs are down.

Top module: `refclk_switch`

## Requirements
- R1: With `prim_aux`=0 the crystal input is primary and the auxiliary input is secondary; with `prim_aux`=1 the roles are swapped. In manual mode `man_sel`=0 routes the primary and `man_sel`=1 routes the secondary. `act_sec` reports 0 for primary and 1 for secondary.
- R2: With `sw_mode` = 00 or 01 (manual), the selection follows `man_sel` only. Loss of the selected input causes no switch.
- R3: With `sw_mode`=10 (automatic), loss of the primary while the secondary is valid switches to the secondary. The block never returns to the primary on its own.
- R4: With `sw_mode`=11 (revertive), the block fails over as in R3. It returns to the primary once the primary is valid again.
- R5: An input is marked invalid at the end of a window of `WIN` monitor cycles in which fewer than `MIN_TOG` edges of its divided clock were seen. Its sticky loss output then goes to 1.
- R6: An invalid input becomes valid after `REQUAL` consecutive active windows. For the crystal input with `xtal_byp`=0 (oscillator mode) it needs 2*`REQUAL` windows.
- R7: `clk_out` never carries a high or low pulse shorter than the shorter half period of the two input clocks.
- R8: When both inputs are invalid in an automatic mode, the selection holds and `both_lost` is 1. `both_lost` returns to 0 when either input is valid.
- R9: In an automatic mode, loss of the selected secondary never causes a switch back to an invalid primary.
- R10: A one-cycle `clr_lost` pulse clears a sticky loss flag only if its input is valid at that time. An input that is still lost keeps its flag at 1.
- R11: After reset, `act_sec`, both loss flags and `both_lost` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| mon_clk | input | 1 | Free-running monitor and control clock |
| rst | input | 1 | Asynchronous active-high reset |
| clk_xtal | input | 1 | Crystal or external reference clock input |
| clk_aux | input | 1 | Auxiliary clock input |
| xtal_byp | input | 1 | 1: crystal input is a driven clock; 0: oscillator (longer requalification) |
| prim_aux | input | 1 | 0: crystal input primary; 1: auxiliary input primary |
| man_sel | input | 1 | Manual pick: 0 primary, 1 secondary |
| sw_mode | input | 2 | 00/01 manual, 10 automatic, 11 revertive |
| clr_lost | input | 1 | Clear strobe for sticky loss flags |
| clk_out | output | 1 | Selected reference clock |
| act_sec | output | 1 | Active source: 0 primary, 1 secondary |
| lost_xtal | output | 1 | Sticky loss flag, crystal input |
| lost_aux | output | 1 | Sticky loss flag, auxiliary input |
| both_lost | output | 1 | Both inputs currently invalid |

## Verification
The bench builds the block with `WIN`=24, `MIN_TOG`=2 and `REQUAL`=3. This puts each loss, the requalification runs and the doubled crystal delay within a few hundred monitor cycles. The input clocks run at 38 ns and 62 ns periods, so each window holds several edges of each divided input. The selected source is identified by counting output edges over a fixed interval. Requalification checks sample at points where the lower and upper window counts since restart are unambiguous.

// File: rtl/refclk_switch.sv
`timescale 1ns/1ps
module refclk_switch #(
  parameter int WIN     = 64,
  parameter int MIN_TOG = 2,
  parameter int REQUAL  = 4
) (
  input  logic       mon_clk,
  input  logic       rst,
  input  logic       clk_xtal,
  input  logic       clk_aux,
  input  logic       xtal_byp,
  input  logic       prim_aux,
  input  logic       man_sel,
  input  logic [1:0] sw_mode,
  input  logic       clr_lost,
  output logic       clk_out,
  output logic       act_sec,
  output logic       lost_xtal,
  output logic       lost_aux,
  output logic       both_lost
);
  localparam int CW = $clog2(WIN + 1);
  localparam int WW = (WIN > 1) ? $clog2(WIN) : 1;
  localparam int SW = $clog2(2 * REQUAL + 1);
  localparam logic [SW-1:0] NEED_CLK  = SW'(REQUAL);
  localparam logic [SW-1:0] NEED_XTAL = SW'(2 * REQUAL);

  logic [WW-1:0] win_cnt;
  logic          win_end;
  logic [1:0]    rclk, val, en, lost;
  logic          sel_sec, src_phys, prim_val, sec_val;

  assign rclk     = {clk_aux, clk_xtal};
  assign win_end  = (win_cnt == WW'(WIN - 1));
  assign prim_val = prim_aux ? val[1] : val[0];
  assign sec_val  = prim_aux ? val[0] : val[1];
  assign src_phys = sel_sec ^ prim_aux;

  always_ff @(posedge mon_clk or posedge rst)
    if (rst) win_cnt <= '0;
    else     win_cnt <= win_end ? '0 : win_cnt + 1'b1;

  for (genvar g = 0; g < 2; g++) begin : g_in
    logic          tg, s1, s2, s3, v, e1, e, clrd, want;
    logic [CW-1:0] cnt;
    logic [SW-1:0] streak, need;

    always_ff @(posedge rclk[g] or posedge rst)
      if (rst) tg <= 1'b0;
      else     tg <= ~tg;

    always_ff @(posedge mon_clk or posedge rst)
      if (rst) {s3, s2, s1} <= '0;
      else     {s3, s2, s1} <= {s2, s1, tg};

    assign need = (g == 0 && !xtal_byp) ? NEED_XTAL : NEED_CLK;

    always_ff @(posedge mon_clk or posedge rst)
      if (rst) begin
        cnt <= '0; streak <= '0; v <= 1'b1;
      end else if (win_end) begin
        cnt <= '0;
        if (cnt < CW'(MIN_TOG)) begin
          v <= 1'b0; streak <= '0;
        end else if (!v) begin
          if (streak + SW'(1) >= need) begin v <= 1'b1; streak <= '0; end
          else streak <= streak + SW'(1);
        end
      end else if (s2 ^ s3) begin
        cnt <= cnt + 1'b1;
      end

    assign clrd = rst | ~v;
    assign want = (src_phys == g[0]);

    always_ff @(negedge rclk[g] or posedge clrd)
      if (clrd) {e, e1} <= '0;
      else begin
        e1 <= want & ~en[1-g];
        e  <= e1;
      end

    always_ff @(posedge mon_clk or posedge rst)
      if (rst) lost[g] <= 1'b0;
      else     lost[g] <= (lost[g] & ~clr_lost) | ~v;

    assign val[g] = v;
    assign en[g]  = e;
  end

  always_ff @(posedge mon_clk or posedge rst)
    if (rst)                             sel_sec <= 1'b0;
    else if (!sw_mode[1])                sel_sec <= man_sel;
    else if (!sel_sec && !prim_val && sec_val) sel_sec <= 1'b1;
    else if (sw_mode[0] && sel_sec && prim_val) sel_sec <= 1'b0;

  always_ff @(posedge mon_clk or posedge rst)
    if (rst) both_lost <= 1'b0;
    else     both_lost <= ~val[0] & ~val[1];

  assign clk_out   = (clk_xtal & en[0]) | (clk_aux & en[1]);
  assign act_sec   = sel_sec;
  assign lost_xtal = lost[0];
  assign lost_aux  = lost[1];

  a_r7_enables_exclusive: assert property (@(posedge mon_clk) disable iff (rst)
    !(en[0] && en[1]));
  a_r3_auto_stays_secondary: assert property (@(posedge mon_clk) disable iff (rst)
    (sw_mode == 2'b10 && act_sec) |=> act_sec);
  a_r9_no_return_to_dead_primary: assert property (@(posedge mon_clk) disable iff (rst)
    (sw_mode[1] && act_sec && !prim_val) |=> act_sec);
  a_r8_hold_when_both_lost: assert property (@(posedge mon_clk) disable iff (rst)
    (sw_mode[1] && !val[0] && !val[1]) |=> $stable(sel_sec));
  a_r5_loss_flag_sticky: assert property (@(posedge mon_clk) disable iff (rst)
    (lost_xtal && !clr_lost) |=> lost_xtal);
  a_r5_aux_flag_sticky: assert property (@(posedge mon_clk) disable iff (rst)
    (lost_aux && !clr_lost) |=> lost_aux);
endmodule

// File: tb/tb_refclk_switch.sv
`timescale 1ns/1ps
module tb_refclk_switch;
  localparam int WIN = 24, MIN_TOG = 2, REQUAL = 3;

  logic mon_clk = 0, rst = 1;
  logic raw_a = 0, raw_b = 0, run_a = 1, run_b = 1, ga = 1, gb = 1;
  logic xtal_byp = 1, prim_aux = 0, man_sel = 0, clr_lost = 0;
  logic [1:0] sw_mode = 2'b00;
  logic clk_a, clk_b, clk_out, act_sec, lost_xtal, lost_aux, both_lost;
  int checks = 0, failures = 0, out_edges = 0, glitches = 0;
  real last_t = 0.0;

  always #5 mon_clk = ~mon_clk;
  always #19 raw_a = ~raw_a;
  initial begin #7; forever #31 raw_b = ~raw_b; end
  always @(negedge raw_a) ga <= run_a;
  always @(negedge raw_b) gb <= run_b;
  assign clk_a = raw_a & ga;
  assign clk_b = raw_b & gb;

  refclk_switch #(.WIN(WIN), .MIN_TOG(MIN_TOG), .REQUAL(REQUAL)) dut (
    .mon_clk(mon_clk), .rst(rst), .clk_xtal(clk_a), .clk_aux(clk_b),
    .xtal_byp(xtal_byp), .prim_aux(prim_aux), .man_sel(man_sel),
    .sw_mode(sw_mode), .clr_lost(clr_lost), .clk_out(clk_out),
    .act_sec(act_sec), .lost_xtal(lost_xtal), .lost_aux(lost_aux),
    .both_lost(both_lost));

  always @(posedge clk_out) out_edges++;
  always @(clk_out) begin
    if (!rst && last_t > 0.0 && ($realtime - last_t) < 18.0) glitches++;
    last_t = $realtime;
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic wwin(input int n);
    repeat (n * WIN) @(posedge mon_clk);
    #1;
  endtask

  // phys: 0 crystal, 1 auxiliary, 2 none
  task automatic chk_src(input int phys, input string req);
    int s, n, lo, hi, nom;
    #400;
    s = out_edges;
    #2000;
    n = out_edges - s;
    if (phys == 0)      begin lo = 49; hi = 56; nom = 53; end
    else if (phys == 1) begin lo = 29; hi = 36; nom = 32; end
    else                begin lo = 0;  hi = 0;  nom = 0;  end
    chk(n >= lo && n <= hi, req, n, nom);
  endtask

  initial begin
    #100000000;
    failures++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    #33;
    chk(act_sec == 0, "R11 act_sec", act_sec, 0);
    chk({lost_xtal, lost_aux, both_lost} == 3'b000, "R11 flags",
        {lost_xtal, lost_aux, both_lost}, 0);
    @(negedge mon_clk); rst = 0;
    wwin(2);

    chk_src(0, "R1 manual primary crystal");
    man_sel = 1; wwin(1);
    chk(act_sec == 1, "R1 act_sec secondary", act_sec, 1);
    chk_src(1, "R1 manual secondary aux");
    prim_aux = 1; man_sel = 0; wwin(1);
    chk_src(1, "R1 swapped primary aux");
    man_sel = 1; wwin(1);
    chk_src(0, "R1 swapped secondary crystal");

    prim_aux = 0; man_sel = 0; sw_mode = 2'b01; wwin(1);
    run_a = 0; wwin(3);
    chk(act_sec == 0, "R2 manual no failover", act_sec, 0);
    chk(lost_xtal == 1 && lost_aux == 0, "R5 crystal loss flag", {lost_xtal, lost_aux}, 2);
    chk_src(2, "R2 dead selected input stays selected");
    @(negedge mon_clk); clr_lost = 1; @(negedge mon_clk); clr_lost = 0; #1;
    chk(lost_xtal == 1, "R10 clear while lost", lost_xtal, 1);
    run_a = 1; wwin(6);
    @(negedge mon_clk); clr_lost = 1; @(negedge mon_clk); clr_lost = 0; #1;
    chk(lost_xtal == 0, "R10 clear after recovery", lost_xtal, 0);

    sw_mode = 2'b10; wwin(1);
    run_a = 0; wwin(3);
    chk(act_sec == 1, "R3 auto failover", act_sec, 1);
    chk_src(1, "R3 output on secondary");
    run_a = 1; wwin(8);
    chk(act_sec == 1, "R3 no return", act_sec, 1);

    sw_mode = 2'b11; wwin(1);
    chk(act_sec == 0, "R4 revert to valid primary", act_sec, 0);
    run_a = 0; wwin(3);
    chk(act_sec == 1, "R4 failover", act_sec, 1);
    run_a = 1; wwin(1);
    chk(act_sec == 1, "R6 requalification not yet done", act_sec, 1);
    wwin(5);
    chk(act_sec == 0, "R4 R6 returned after requalification", act_sec, 0);
    chk_src(0, "R4 output back on primary");

    xtal_byp = 0;
    run_a = 0; wwin(3);
    chk(act_sec == 1, "R4 crystal failover", act_sec, 1);
    run_a = 1; wwin(4);
    chk(act_sec == 1, "R6 oscillator needs doubled run", act_sec, 1);
    wwin(5);
    chk(act_sec == 0, "R6 oscillator requalified", act_sec, 0);
    xtal_byp = 1;

    run_a = 0; wwin(3);
    chk(act_sec == 1, "R4 failover before both lost", act_sec, 1);
    run_b = 0; wwin(3);
    chk(act_sec == 1, "R9 no switch to dead primary", act_sec, 1);
    chk(both_lost == 1, "R8 both_lost set", both_lost, 1);
    chk(lost_aux == 1, "R5 aux loss flag", lost_aux, 1);
    chk_src(2, "R8 no output while both dead");
    run_b = 1; wwin(5);
    chk(both_lost == 0, "R8 both_lost cleared", both_lost, 0);
    chk(act_sec == 1, "R8 held selection", act_sec, 1);
    chk_src(1, "R8 output resumes on secondary");
    run_a = 1; wwin(6);
    chk(act_sec == 0, "R4 revert after both lost", act_sec, 0);
    @(negedge mon_clk); clr_lost = 1; @(negedge mon_clk); clr_lost = 0; #1;
    chk({lost_xtal, lost_aux} == 2'b00, "R10 both flags cleared", {lost_xtal, lost_aux}, 0);

    prim_aux = 1; sw_mode = 2'b10; wwin(1);
    run_b = 0; wwin(3);
    chk(act_sec == 1, "R3 R1 swapped failover", act_sec, 1);
    chk_src(0, "R1 swapped secondary is crystal");
    run_b = 1; wwin(6);
    chk(act_sec == 1, "R3 swapped no return", act_sec, 1);

    chk(glitches == 0, "R7 pulse width", glitches, 0);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule